// File: doc/BRIEF.md
# Round-Robin Interrupt Aggregator with Cascaded External Range

The block gathers a bank of level-held interrupt lines from on-chip peripherals into a status register and gates that register with a software-owned enable mask. The bitwise AND of the two is the pending set. An OR of the pending set drives one summary interrupt toward the processor. A round-robin picker names the next source to service. The picker scans from a stored pointer and does not favour any line over another. Each time the consumer takes the presented source, the pointer moves just past it.

The bank width is fixed at build time to 32 or 64 lines. Cascading may be enabled so that a run of 4 or 6 consecutive status bits is reserved for external interrupt pins. A source picked from that run is reported as an external number, counted from the first bit of the run. Any other source is reported with its own bit number. Software reads the status and the mask. It can overwrite the whole mask, or set or clear a single mask bit.

Top module: `irq_rr_aggregator`

## Requirements
- R1: After reset, the mask is all zeros, the summary interrupt is 0 and no source is presented (pick_valid_o = 0). The scan pointer starts at bit 0.
- R2: stat_o shows src_i as captured at the previous clock edge. A source counts as pending only when its status bit and its mask bit are both 1. pick_valid_o is 1 exactly when some source is pending.
- R3: irq_o is the OR of the pending bits, and it follows one clock after the status or mask change that causes it.
- R4: On a clock with cfg_we = 1, cfg_op selects the mask action. 2'b00 loads the whole mask from cfg_wdata. 2'b01 sets only bit cfg_idx. 2'b10 clears only bit cfg_idx. 2'b11 leaves the mask unchanged. The set and clear actions leave every other bit as it was.
- R5: The presented source is the first pending bit at or after the scan pointer, searching upward and wrapping past the top bit to bit 0.
- R6: A clock with pop_i = 1 while a source is presented moves the pointer to one past the presented bit, modulo the bank width.
- R7: A clock with pop_i = 1 while nothing is pending leaves the pointer where it was.
- R8: While pop_i stays 0 and the status and mask stay unchanged, the presented source stays unchanged.
- R9: With cascading enabled (defaults: run starts at bit 44, 6 bits), a pick inside the run gives pick_ext_o = 1 and pick_num_o = bit − 44. A pick outside the run gives pick_ext_o = 0 and pick_num_o = bit.
- R10: The bank width parameter is 32 or 64 (default 64). Pointer arithmetic wraps at that width, so a pop at the top bit returns the scan to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | SRC_W | Raw level interrupt lines |
| cfg_we | input | 1 | Mask action strobe |
| cfg_op | input | 2 | Mask action: 00 load, 01 set bit, 10 clear bit, 11 none |
| cfg_idx | input | 6 | Bit index for set and clear |
| cfg_wdata | input | SRC_W | Mask value for load |
| pop_i | input | 1 | Consumer takes the presented source |
| stat_o | output | SRC_W | Captured status register |
| mask_o | output | SRC_W | Enable mask register |
| irq_o | output | 1 | Registered summary interrupt |
| pick_valid_o | output | 1 | A source is presented |
| pick_ext_o | output | 1 | Presented source lies in the external run |
| pick_num_o | output | 6 | Presented source number, internal or external |

## Verification
The hardest state to reach from the ports is a pointer that sits somewhere other than zero while nothing is pending. A pop in that state must leave the pointer untouched. The stimulus first walks the pointer forward with real pops. It then drops every line and pops while the bank is idle. Finally it raises one line below the pointer and one line at the pointer: the line at the pointer must win. A second case pops at the top bit, so the wrap to bit 0 shows up in the next pick. Lines at both ends of the external run and just outside it check the relabelling.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Widest index the block ever presents (covers a 64-line bank)
    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        MASK_LOAD = 2'b00,
        MASK_SET  = 2'b01,
        MASK_CLR  = 2'b10,
        MASK_NOP  = 2'b11
    } mask_op_e;

    typedef struct packed {
        logic             valid;
        logic             ext;
        logic [IDX_W-1:0] num;
    } pick_t;

    // True when bit b lies inside the reserved external run
    function automatic logic in_run(input logic [IDX_W-1:0] b, input int lo, input int cnt);
        return (int'(b) >= lo) && (int'(b) <= lo + cnt - 1);
    endfunction

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SRC_W-1:0]       src_i,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_op,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [SRC_W-1:0]       cfg_wdata,
    output logic [SRC_W-1:0]       stat_q,
    output logic [SRC_W-1:0]       mask_q,
    output logic [SRC_W-1:0]       pend,
    output logic                   irq_q
);
    localparam int IW = $clog2(SRC_W);

    logic [IW-1:0] bit_sel;
    mask_op_e      op;

    assign bit_sel = cfg_idx[IW-1:0];
    assign op      = mask_op_e'(cfg_op);
    assign pend    = stat_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= src_i;
            irq_q  <= |pend;
            if (cfg_we) begin
                case (op)
                    MASK_LOAD: mask_q <= cfg_wdata;
                    MASK_SET:  mask_q[bit_sel] <= 1'b1;
                    MASK_CLR:  mask_q[bit_sel] <= 1'b0;
                    default:   mask_q <= mask_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_rr_picker.sv
module irq_rr_picker #(
    parameter int SRC_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SRC_W-1:0]          pend,
    input  logic                      pop_i,
    output logic                      sel_valid,
    output logic [$clog2(SRC_W)-1:0]  sel_bit
);
    localparam int IW = $clog2(SRC_W);

    logic [IW-1:0]      ptr_q;
    logic [2*SRC_W-1:0] dbl;
    logic [SRC_W-1:0]   rot;
    logic [IW-1:0]      off;

    assign dbl = {pend, pend};
    assign rot = dbl[ptr_q +: SRC_W];

    // Lowest set bit of the rotated vector is the distance from the pointer
    always_comb begin
        off = '0;
        for (int i = SRC_W - 1; i >= 0; i--) begin
            if (rot[i]) off = IW'(i);
        end
    end

    assign sel_valid = |pend;
    assign sel_bit   = ptr_q + off;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (pop_i && sel_valid) begin
            ptr_q <= sel_bit + 1'b1;
        end
    end
endmodule

// File: rtl/irq_num_map.sv
module irq_num_map
    import irq_agg_pkg::*;
#(
    parameter int SRC_W      = 64,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_LO     = 44,
    parameter int EXT_CNT    = 6
) (
    input  logic                     sel_valid,
    input  logic [$clog2(SRC_W)-1:0] sel_bit,
    output pick_t                    pick
);
    logic [IDX_W-1:0] b;
    assign b = IDX_W'(sel_bit);

    generate
        if (CASCADE_EN) begin : g_cascade
            logic hit;
            assign hit        = in_run(b, EXT_LO, EXT_CNT);
            assign pick.valid = sel_valid;
            assign pick.ext   = sel_valid & hit;
            assign pick.num   = hit ? (b - IDX_W'(EXT_LO)) : b;
        end else begin : g_flat
            assign pick.valid = sel_valid;
            assign pick.ext   = 1'b0;
            assign pick.num   = b;
        end
    endgenerate
endmodule

// File: rtl/irq_rr_aggregator.sv
module irq_rr_aggregator
    import irq_agg_pkg::*;
#(
    parameter int SRC_W      = 64,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_LO     = 44,
    parameter int EXT_CNT    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_i,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_op,
    input  logic [5:0]       cfg_idx,
    input  logic [SRC_W-1:0] cfg_wdata,
    input  logic             pop_i,
    output logic [SRC_W-1:0] stat_o,
    output logic [SRC_W-1:0] mask_o,
    output logic             irq_o,
    output logic             pick_valid_o,
    output logic             pick_ext_o,
    output logic [5:0]       pick_num_o
);
    localparam int IW = $clog2(SRC_W);

    logic [SRC_W-1:0] pend;
    logic             sel_valid;
    logic [IW-1:0]    sel_bit;
    pick_t            pick;

    irq_agg_regs #(.SRC_W(SRC_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .cfg_we    (cfg_we),
        .cfg_op    (cfg_op),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .stat_q    (stat_o),
        .mask_q    (mask_o),
        .pend      (pend),
        .irq_q     (irq_o)
    );

    irq_rr_picker #(.SRC_W(SRC_W)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .pop_i     (pop_i),
        .sel_valid (sel_valid),
        .sel_bit   (sel_bit)
    );

    irq_num_map #(
        .SRC_W      (SRC_W),
        .CASCADE_EN (CASCADE_EN),
        .EXT_LO     (EXT_LO),
        .EXT_CNT    (EXT_CNT)
    ) u_map (
        .sel_valid (sel_valid),
        .sel_bit   (sel_bit),
        .pick      (pick)
    );

    assign pick_valid_o = pick.valid;
    assign pick_ext_o   = pick.ext;
    assign pick_num_o   = pick.num;
endmodule

// File: rtl/irq_rr_aggregator_chk.sv
module irq_rr_aggregator_chk #(
    parameter int SRC_W   = 64,
    parameter int EXT_CNT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [1:0]       cfg_op,
    input logic [5:0]       cfg_idx,
    input logic             pop_i,
    input logic [SRC_W-1:0] stat_o,
    input logic [SRC_W-1:0] mask_o,
    input logic             irq_o,
    input logic             pick_valid_o,
    input logic             pick_ext_o,
    input logic [5:0]       pick_num_o
);
    localparam int IW = $clog2(SRC_W);
    localparam logic [SRC_W-1:0] ONE = 1;

    // R3
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_o == $past(|(stat_o & mask_o)));

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == 2'b01) |=>
            mask_o == ($past(mask_o) | (ONE << $past(cfg_idx[IW-1:0]))));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == 2'b10) |=>
            mask_o == ($past(mask_o) & ~(ONE << $past(cfg_idx[IW-1:0]))));

    // R8
    pick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pop_i) && $stable(stat_o) && $stable(mask_o))
            |-> ($stable(pick_num_o) && $stable(pick_ext_o)));

    // R9
    ext_range_chk: assert property (@(posedge clk) disable iff (rst)
        pick_ext_o |-> (pick_valid_o && int'(pick_num_o) < EXT_CNT));
endmodule

bind irq_rr_aggregator irq_rr_aggregator_chk #(.SRC_W(SRC_W), .EXT_CNT(EXT_CNT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_op       (cfg_op),
    .cfg_idx      (cfg_idx),
    .pop_i        (pop_i),
    .stat_o       (stat_o),
    .mask_o       (mask_o),
    .irq_o        (irq_o),
    .pick_valid_o (pick_valid_o),
    .pick_ext_o   (pick_ext_o),
    .pick_num_o   (pick_num_o)
);

// File: tb/irq_rr_aggregator_test.sv
`timescale 1ns/1ps
module irq_rr_aggregator_test;
    localparam int W      = 64;
    localparam int EXT_LO = 44;
    localparam int EXT_N  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  src_i = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = 2'b11;
    logic [5:0]    cfg_idx = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          pop_i = 1'b0;
    logic [W-1:0]  stat_o, mask_o;
    logic          irq_o, pick_valid_o, pick_ext_o;
    logic [5:0]    pick_num_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] src_m = '0;
    logic [W-1:0] mask_m = '0;
    int ptr_m = 0;

    always #2.5 clk = ~clk;

    irq_rr_aggregator uut (
        .clk(clk), .rst(rst), .src_i(src_i), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .pop_i(pop_i),
        .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o),
        .pick_valid_o(pick_valid_o), .pick_ext_o(pick_ext_o), .pick_num_o(pick_num_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] pend, input int p, output bit v, output int b);
        v = 0;
        b = 0;
        for (int k = 0; k < W; k++) begin
            int c;
            c = (p + k) % W;
            if (!v && pend[c]) begin
                v = 1;
                b = c;
            end
        end
    endfunction

    task automatic chk_pick(input string req);
        bit v;
        int b;
        bit e;
        int n;
        model(src_m & mask_m, ptr_m, v, b);
        e = v && (b >= EXT_LO) && (b <= EXT_LO + EXT_N - 1);
        n = e ? b - EXT_LO : b;
        chk(req, "pick_valid", W'(pick_valid_o), W'(v));
        if (v) begin
            chk(req, "pick_ext", W'(pick_ext_o), W'(e));
            chk(req, "pick_num", W'(pick_num_o), W'(n));
        end
    endtask

    task automatic set_src(input logic [W-1:0] s);
        src_i = s;
        src_m = s;
        tick();
    endtask

    task automatic cfg(input logic [1:0] op, input int idx, input logic [W-1:0] d);
        cfg_we = 1'b1;
        cfg_op = op;
        cfg_idx = 6'(idx);
        cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
        case (op)
            2'b00: mask_m = d;
            2'b01: mask_m[idx] = 1'b1;
            2'b10: mask_m[idx] = 1'b0;
            default: ;
        endcase
    endtask

    task automatic pop();
        bit v;
        int b;
        model(src_m & mask_m, ptr_m, v, b);
        pop_i = 1'b1;
        tick();
        pop_i = 1'b0;
        if (v) ptr_m = (b + 1) % W;
    endtask

    task automatic t_reset();
        chk("R1", "mask after reset", mask_o, '0);
        chk("R1", "irq after reset", W'(irq_o), '0);
        chk("R1", "valid after reset", W'(pick_valid_o), '0);
    endtask

    task automatic t_mask_ops();
        cfg(2'b00, 0, 64'hF0F0_0000_1234_00F0);
        chk("R4", "load", mask_o, mask_m);
        cfg(2'b01, 3, '0);
        chk("R4", "set bit 3", mask_o, mask_m);
        cfg(2'b10, 4, '0);
        chk("R4", "clear bit 4", mask_o, mask_m);
        cfg(2'b11, 7, '1);
        chk("R4", "no-op", mask_o, 64'hF0F0_0000_1234_00E8);
    endtask

    task automatic t_gate_irq();
        cfg(2'b00, 0, '1);
        cfg(2'b10, 10, '0);
        set_src(64'h400);
        chk("R2", "status capture", stat_o, 64'h400);
        chk("R2", "masked line not pending", W'(pick_valid_o), '0);
        tick();
        chk("R3", "masked line no irq", W'(irq_o), '0);
        set_src(64'h420);
        chk("R2", "unmasked line pending", W'(pick_valid_o), 1);
        chk("R3", "irq lags a cycle", W'(irq_o), '0);
        tick();
        chk("R3", "irq raised", W'(irq_o), 1);
        chk_pick("R5");
        cfg(2'b00, 0, '1);
    endtask

    task automatic t_round_robin();
        set_src((64'h1 << 5) | (64'h1 << 20) | (64'h1 << 63));
        chk_pick("R5");
        chk("R5", "first pick", W'(pick_num_o), 5);
        tick();
        tick();
        chk_pick("R8");
        chk("R8", "held pick", W'(pick_num_o), 5);
        pop();
        chk_pick("R6");
        chk("R6", "after pop", W'(pick_num_o), 20);
        pop();
        chk("R6", "after second pop", W'(pick_num_o), 63);
        pop();
        chk_pick("R10");
        chk("R10", "wrap to low bit", W'(pick_num_o), 5);
        pop();
        chk("R6", "pointer model", W'(ptr_m), 6);
    endtask

    task automatic t_empty_pop();
        set_src('0);
        chk("R2", "nothing pending", W'(pick_valid_o), '0);
        pop();
        pop();
        set_src((64'h1 << 2) | (64'h1 << 6));
        chk_pick("R7");
        chk("R7", "pointer kept over idle pops", W'(pick_num_o), 6);
    endtask

    task automatic t_cascade();
        set_src((64'h1 << 43) | (64'h1 << 44) | (64'h1 << 49) | (64'h1 << 50));
        chk_pick("R9");
        chk("R9", "below run internal", W'(pick_num_o), 43);
        chk("R9", "below run flag", W'(pick_ext_o), 0);
        pop();
        chk_pick("R9");
        chk("R9", "run start ext", W'(pick_num_o), 0);
        pop();
        chk("R9", "run end ext", W'(pick_num_o), 5);
        chk("R9", "run end flag", W'(pick_ext_o), 1);
        pop();
        chk("R9", "above run internal", W'(pick_num_o), 50);
        chk("R9", "above run flag", W'(pick_ext_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        tick();
        t_reset();
        t_mask_ops();
        t_gate_irq();
        t_round_robin();
        t_empty_pop();
        t_cascade();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule